// File: doc/BRIEF.md
# Multi-format serial audio data receiver

This block takes sample data from one serial line and turns it into parallel words. Three externally driven signals carry the data: a bit clock, a left/right (or frame sync) clock and the data line itself. The block is always a slave on this link. It oversamples all three lines with its own faster system clock, finds the rising edges of the bit clock, and tracks each bit's position relative to the last framing edge.

A 3-bit format field chooses how words sit in the frame. The formats are delayed-MSB stereo, left-justified, right-justified, a pulse-synchronised format, and a packed 256-clock frame that carries six channels. A 2-bit field chooses a word length of 16, 18, 20 or 24 bits. Each completed word comes out as a 24-bit left-aligned sample with a channel index and a one-cycle valid strobe. Both fields are taken up only at a frame start, so a word is never decoded half in one layout and half in another.

Top module: `aud_ser_rx`

## Requirements
- R1: After reset, valid_o is 0, sample_o is 0 and chan_o is 0. Before the first frame start the active format is delayed-MSB stereo with 24-bit words.
- R2: Format code 000 (delayed-MSB stereo): the MSB is taken on the second rising bit-clock edge after a left/right transition. Words taken while left/right is low get chan_o 0, and words taken while it is high get chan_o 1.
- R3: Format code 011 (left-justified): the MSB is taken on the first rising edge after a left/right transition, with the same channel mapping as R2.
- R4: Format code 001 (right-justified): each half has 32 bit slots, and the LSB is taken on the 32nd rising edge after the transition. The MSB therefore falls on edge 33 minus the word length. The channel mapping is the same as R2.
- R5: Format code 010 (pulse sync): a frame starts at a rising edge where the sync line is first seen high. The first word's MSB follows on the next edge and the second word's MSB 32 edges later. These words get chan_o 0 and 1, taken from their slot position alone.
- R6: Format code 100 (packed): left/right low marks the left half and high marks the right half. Each half holds 32-bit slots starting at the transition edge, left-justified. Slots 0 to 2 of a half carry words with chan_o = 2*slot + (1 if right half), and the fourth slot is ignored.
- R7: Length codes 00, 01, 10 and 11 select 16, 18, 20 and 24 bits. A word is MSB first and left-aligned in sample_o, with the low bits zero. Slot bits beyond the length do not reach sample_o.
- R8: The format and length fields are latched only at a frame start. In pulse-sync format a frame start is a rising left/right edge; in every other format it is a falling edge. A frame in progress completes in its old layout.
- R9: After reset, bits received before the first frame start produce no output word.
- R10: Format codes 101, 110 and 111 behave as code 000.
- R11: valid_o is high for exactly one system clock per received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | External bit clock; data is taken on its rising edge |
| lrclk_i | input | 1 | External left/right clock or frame sync pulse |
| sdata_i | input | 1 | Serial data line |
| fmt_i | input | 3 | Framing format request |
| wlen_i | input | 2 | Word length request |
| sample_o | output | 24 | Received word, left-aligned and zero-padded |
| chan_o | output | 3 | Channel index of sample_o |
| valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The hardest condition to bring about is a format request that changes in the middle of a frame. A frame that is already running must finish in the old layout, and the new layout must be decoded correctly from the very next frame start. The bench switches the request partway through a left-justified frame, moving it to right-justified with a different length. It then checks that both words of that frame still follow the old layout and that the next frame follows the new one. Every format and length pair is also reached through priming frames sent in the old and new layouts. The bits outside each word carry a nonzero filler, so a word that picks up stray bits shows up as a wrong value.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S = 3'd0,
    FMT_RJ  = 3'd1,
    FMT_DSP = 3'd2,
    FMT_LJ  = 3'd3,
    FMT_PK  = 3'd4
  } fmt_e;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd18;
      2'b10:   return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  // reserved codes fall back to the delayed-MSB layout
  function automatic fmt_e fmt_decode(input logic [2:0] code);
    return (code > 3'd4) ? FMT_I2S : fmt_e'(code);
  endfunction

endpackage

// File: rtl/aud_ser_sync.sv
module aud_ser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= '0;
      end else if (s == 0) begin
        stg_q[s] <= d_i;
      end else begin
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
  import aud_ser_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             lr_i,
  input  logic             sd_i,
  input  logic [2:0]       fmt_i,
  input  logic [1:0]       wlen_i,
  output logic             stb_o,
  output logic             sd_o,
  output logic             lr_o,
  output logic [CNT_W-1:0] cnt_o,
  output fmt_e             fmt_o,
  output logic [1:0]       wlen_o,
  output logic             armed_o
);

  logic bclk_d;
  logic edge_w, rise_w, fall_w, frm_start, cnt_clr;
  fmt_e fmt_new;

  assign edge_w    = bclk_i & ~bclk_d;
  // lr_o holds the left/right level seen at the previous bit edge
  assign rise_w    = edge_w &  lr_i & ~lr_o;
  assign fall_w    = edge_w & ~lr_i &  lr_o;
  assign frm_start = (fmt_o == FMT_DSP) ? rise_w : fall_w;
  assign cnt_clr   = (fmt_o == FMT_DSP) ? rise_w : (rise_w | fall_w);
  assign fmt_new   = fmt_decode(fmt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d  <= 1'b0;
      stb_o   <= 1'b0;
      sd_o    <= 1'b0;
      lr_o    <= 1'b0;
      cnt_o   <= '0;
      fmt_o   <= FMT_I2S;
      wlen_o  <= 2'b11;
      armed_o <= 1'b0;
    end else begin
      bclk_d <= bclk_i;
      stb_o  <= edge_w;
      if (edge_w) begin
        sd_o <= sd_i;
        lr_o <= lr_i;
        if (cnt_clr)           cnt_o <= '0;
        else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
      end
      if (frm_start) begin
        fmt_o  <= fmt_new;
        wlen_o <= wlen_i;
        // switching between pulse sync and level framing needs a fresh start
        armed_o <= ((fmt_new == FMT_DSP) == (fmt_o == FMT_DSP));
      end
    end
  end

endmodule

// File: rtl/aud_ser_slot.sv
module aud_ser_slot
  import aud_ser_rx_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CNT_W    = 8,
  parameter int SLOT_LG  = 5,
  parameter int PK_SLOTS = 3,
  parameter int CH_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              sd_i,
  input  logic              lr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  fmt_e              fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              armed_i,
  output logic [DATA_W-1:0] sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);

  localparam int SLOT_N = 1 << SLOT_LG;
  localparam int SEL_W  = CNT_W - SLOT_LG;

  logic [5:0]         wbits, lead, bitpos;
  logic [CNT_W-1:0]   rel;
  logic [SEL_W-1:0]   slot;
  logic [5:0]         pos;
  logic               dly, in_rng, slot_ok, hit, last;
  logic [CH_W-1:0]    ch;
  logic [DATA_W-1:0]  sh_q, sh_nxt;

  assign wbits  = wlen_bits(wlen_i);
  assign dly    = (fmt_i == FMT_I2S) || (fmt_i == FMT_DSP);
  assign in_rng = cnt_i >= CNT_W'(dly);
  assign rel    = cnt_i - CNT_W'(dly);
  assign slot   = rel[CNT_W-1:SLOT_LG];
  assign pos    = 6'(rel[SLOT_LG-1:0]);
  assign lead   = (fmt_i == FMT_RJ) ? (6'(SLOT_N) - wbits) : 6'd0;
  assign bitpos = pos - lead;
  assign last   = (bitpos == wbits - 6'd1);

  always_comb begin
    case (fmt_i)
      FMT_DSP: begin
        slot_ok = slot < SEL_W'(2);
        ch      = CH_W'(slot);
      end
      FMT_PK: begin
        slot_ok = slot < SEL_W'(PK_SLOTS);
        ch      = CH_W'({slot, lr_i});
      end
      default: begin
        slot_ok = slot == '0;
        ch      = CH_W'(lr_i);
      end
    endcase
  end

  assign hit = stb_i && armed_i && in_rng && slot_ok && (pos >= lead) && (bitpos < wbits);

  always_comb begin
    sh_nxt = (bitpos == 6'd0) ? '0 : sh_q;
    sh_nxt[(DATA_W-1) - int'(bitpos)] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sample_o <= '0;
      chan_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= hit && last;
      if (hit) sh_q <= sh_nxt;
      if (hit && last) begin
        sample_o <= sh_nxt;
        chan_o   <= ch;
      end
    end
  end

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_ser_rx_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int SLOT_LG     = 5,
  parameter int PK_SLOTS    = 3,
  parameter int CH_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic [2:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  output logic [DATA_W-1:0] sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);

  logic [2:0]       pins_s;
  logic             bit_stb, bit_sd, bit_lr, armed;
  logic [CNT_W-1:0] bit_cnt;
  fmt_e             act_fmt;
  logic [1:0]       act_wlen;

  aud_ser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclk_i, lrclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  aud_ser_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (pins_s[2]),
    .lr_i   (pins_s[1]),
    .sd_i   (pins_s[0]),
    .fmt_i  (fmt_i),
    .wlen_i (wlen_i),
    .stb_o  (bit_stb),
    .sd_o   (bit_sd),
    .lr_o   (bit_lr),
    .cnt_o  (bit_cnt),
    .fmt_o  (act_fmt),
    .wlen_o (act_wlen),
    .armed_o(armed)
  );

  aud_ser_slot #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .SLOT_LG (SLOT_LG),
    .PK_SLOTS(PK_SLOTS),
    .CH_W    (CH_W)
  ) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (bit_stb),
    .sd_i    (bit_sd),
    .lr_i    (bit_lr),
    .cnt_i   (bit_cnt),
    .fmt_i   (act_fmt),
    .wlen_i  (act_wlen),
    .armed_i (armed),
    .sample_o(sample_o),
    .chan_o  (chan_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk
  import aud_ser_rx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic [CH_W-1:0]   chan_o,
  input logic [DATA_W-1:0] sample_o,
  input fmt_e              act_fmt,
  input logic [1:0]        act_wlen,
  input logic              bit_lr
);

  // R11
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  fmt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_fmt != $past(act_fmt)) |->
      (($past(act_fmt) == FMT_DSP) ? (bit_lr && !$past(bit_lr)) : (!bit_lr && $past(bit_lr))));

  // R5
  dsp_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && act_fmt == FMT_DSP) |-> chan_o <= CH_W'(1));

  // R6
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((act_fmt == FMT_PK) ? (chan_o <= CH_W'(5)) : (chan_o <= CH_W'(1))));

  // R7
  zero_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && act_wlen == 2'b00) |-> sample_o[DATA_W-17:0] == '0);

endmodule

bind aud_ser_rx aud_ser_rx_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .chan_o  (chan_o),
  .sample_o(sample_o),
  .act_fmt (act_fmt),
  .act_wlen(act_wlen),
  .bit_lr  (bit_lr)
);

// File: tb/aud_ser_rx_tb_top.sv
module aud_ser_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_r, lr_r, sd_r;
  logic [2:0]  fmt_r;
  logic [1:0]  wlen_r;
  logic [23:0] sample_o;
  logic [2:0]  chan_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  int cap_n = 0;
  int pulse_bad = 0;
  logic [23:0] cap_s [64];
  int          cap_c [64];
  logic [23:0] exp_s [8];
  int          exp_c [8];
  int          exp_n;
  logic        prev_v = 1'b0;
  int          cur_f, cur_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ser_rx dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .bclk_i  (bclk_r),
    .lrclk_i (lr_r),
    .sdata_i (sd_r),
    .fmt_i   (fmt_r),
    .wlen_i  (wlen_r),
    .sample_o(sample_o),
    .chan_o  (chan_o),
    .valid_o (valid_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      cap_s[cap_n % 64] = sample_o;
      cap_c[cap_n % 64] = int'(chan_o);
      cap_n++;
      if (prev_v) pulse_bad++;
    end
    prev_v = valid_o;
  end

  function automatic int wbits(input int code);
    case (code)
      0: return 16;
      1: return 18;
      2: return 20;
      default: return 24;
    endcase
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic lr, input logic d);
    @(negedge clk);
    bclk_r = 1'b0;
    lr_r   = lr;
    sd_r   = d;
    repeat (HALF) @(negedge clk);
    bclk_r = 1'b1;
    repeat (HALF-1) @(negedge clk);
  endtask

  // chk: 0 none, 1 compare words
  task automatic send_frame(input int f_in, input int wl, input int chk, input string tag,
                            input int chg_at, input int chg_f, input int chg_wl);
    int f, w, n, base;
    logic [23:0] vals [6];
    logic [23:0] mask;
    f = (f_in > 4) ? 0 : f_in;
    w = wbits(wl);
    n = (f == 4) ? 256 : 64;
    mask = 24'hFFFFFF << (24 - w);
    for (int c = 0; c < 6; c++) vals[c] = 24'($urandom);
    exp_n = 0;
    @(posedge clk);
    base = cap_n;
    for (int i = 0; i < n; i++) begin
      logic lrv, act, d;
      int k, ch, h, s;
      lrv = 1'b0; act = 1'b0; k = -1; ch = 0;
      case (f)
        2: begin
          lrv = (i == 0);
          if (i >= 1) begin
            s = (i - 1) / 32; k = (i - 1) % 32; act = (s < 2); ch = s;
          end
        end
        4: begin
          lrv = (i >= 128); h = i % 128; s = h / 32; k = h % 32;
          act = (s < 3); ch = 2 * s + int'(lrv);
        end
        default: begin
          lrv = (i >= 32); h = i % 32; act = 1'b1; ch = int'(lrv);
          k = h - ((f == 0) ? 1 : (f == 3) ? 0 : 32 - w);
        end
      endcase
      d = (act && k >= 0 && k < w) ? vals[ch][23-k] : (i % 3 == 1);
      if (i == chg_at) begin
        fmt_r  = 3'(chg_f);
        wlen_r = 2'(chg_wl);
      end
      bit_out(lrv, d);
      if (chk == 1 && act && k == w - 1) begin
        exp_s[exp_n] = vals[ch] & mask;
        exp_c[exp_n] = ch;
        exp_n++;
      end
    end
    repeat (4) @(posedge clk);
    if (chk != 0) begin
      check_eq(tag, "word count", cap_n - base, exp_n);
      for (int j = 0; j < exp_n; j++) begin
        check_eq({tag, "/R7"}, $sformatf("sample %0d", j), int'(cap_s[(base + j) % 64]), int'(exp_s[j]));
        check_eq(tag, $sformatf("chan %0d", j), cap_c[(base + j) % 64], exp_c[j]);
      end
    end
  endtask

  task automatic run_cfg(input int f, input int wl, input string tag);
    fmt_r  = 3'(f);
    wlen_r = 2'(wl);
    send_frame(cur_f, cur_w, 0, tag, -1, 0, 0);
    send_frame(f, wl, 0, tag, -1, 0, 0);
    send_frame(f, wl, 1, tag, -1, 0, 0);
    cur_f = f;
    cur_w = wl;
  endtask

  function automatic string fmt_tag(input int f);
    case (f)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int order [5] = '{0, 3, 1, 2, 4};
    int base;
    rst_n = 1'b0; bclk_r = 1'b0; lr_r = 1'b0; sd_r = 1'b0;
    fmt_r = 3'd0; wlen_r = 2'd3;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check_eq("R1", "valid_o", int'(valid_o), 0);
    check_eq("R1", "sample_o", int'(sample_o), 0);
    check_eq("R1", "chan_o", int'(chan_o), 0);
    rst_n = 1'b1;

    // R9 bits before the first frame start give no word
    @(posedge clk);
    base = cap_n;
    for (int i = 0; i < 32; i++) bit_out(1'b1, (i % 2 == 0));
    repeat (4) @(posedge clk);
    check_eq("R9", "words before frame start", cap_n - base, 0);

    // R1 default format/length decodes the first frame
    send_frame(0, 3, 1, "R1", -1, 0, 0);
    cur_f = 0; cur_w = 3;

    for (int o = 0; o < 5; o++)
      for (int wl = 0; wl < 4; wl++)
        run_cfg(order[o], wl, fmt_tag(order[o]));

    // R10 reserved codes act as code 000
    run_cfg(5, 2, "R10");
    run_cfg(7, 1, "R10");

    // R8 change mid-frame: old layout completes, new one applies next frame
    run_cfg(3, 3, "R3");
    send_frame(3, 3, 1, "R8", 10, 1, 1);
    send_frame(1, 1, 1, "R8", -1, 0, 0);
    cur_f = 1; cur_w = 1;

    // R11
    check_eq("R11", "back-to-back valid cycles", pulse_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule